// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits between an instruction pipeline and up to sixteen attached coprocessors. It takes one coprocessor instruction at a time over a valid/ready pair. Each instruction names a target coprocessor and an instruction class: a register write, a register read or a data operation. The block then runs the strobe-and-response handshake with the selected unit.

Before anything reaches a coprocessor, the block checks a per-unit permission mask. Data operations that address the floating-point units are sent to a separate dispatch output and skip the handshake.

While a coprocessor answers busy, the sequencer inserts one internal cycle per wait, then polls again. During each wait it weighs pending exceptions. When one is taken, the coprocessor is told that the instruction is abandoned and an exception vector is requested. A coprocessor that cannot execute the instruction causes an undefined-instruction trap. On acceptance, the sequencer marks the coprocessor and internal cycles that the instruction class costs.

Top module: `cp_handshake_seq`

## Requirements
- R1: After synchronous active-high reset the block is idle: `req_ready` is 1, and `cp_strobe`, `trap_undef`, `vec_req`, `fp_dispatch`, `rd_valid` and `done` are 0, with `cyc_type` at 0.
- R2: A request whose coprocessor bit in `cp_allow` is 0, and that is not diverted by R3, gives a one-cycle `trap_undef` in the cycle after acceptance and no `cp_strobe` at all. For a read (class 1), `rd_valid` pulses in that same cycle with `rd_data` equal to `TRAP_RDATA` (default 0xF0000000).
- R3: A data operation (class 2 or 3) addressed to coprocessor 10 or 11 pulses `fp_dispatch` in the cycle after acceptance, with `cp_insn` carrying the instruction. The permission bit is ignored. No strobe and no trap occur, and `done` pulses one cycle later.
- R4: A permitted handshake starts in the cycle after acceptance with `cp_strobe`=1 and `cp_phase`=1 (first), with `cp_sel` and `cp_insn` showing the request.
- R5: The response `cp_resp` is sampled in each strobe cycle whose phase is first or busy (0 accept, 1 busy, 2 or 3 cannot). A busy answer is followed by one cycle with `cyc_type`=1 (internal) and then a strobe with `cp_phase`=2 (busy).
- R6: If an exception is taken in an internal wait cycle, the next cycle carries `cp_strobe` with `cp_phase`=3 (interrupt) and a one-cycle `vec_req`. The instruction is abandoned without `done`, and a read returns `rd_valid` with `rd_data`=0 in that cycle.
- R7: Exceptions are weighed only while `exc_any` is 1. The order is: `rst_req_n` low first (`vec_code` 1), then `fiq_n` low with `fiq_mask` 0 (code 2), then `irq_n` low with `irq_mask` 0 (code 3). Masked or ungated lines leave the handshake running.
- R8: A cannot answer gives a one-cycle `trap_undef` in the next cycle. For a read, `rd_valid` pulses there with `rd_data`=`TRAP_RDATA`.
- R9: When the answer is accept, each class finishes as follows:
  - A write spends one cycle with `cyc_type`=2 (coprocessor), and `done` follows.
  - A read spends one coprocessor cycle and then one internal cycle. The internal cycle carries `rd_valid` with the data present on `cp_rdata` at acceptance, and `done` follows.
  - A data operation pulses `done` in the next cycle, with no extra cycle.
- R10: `req_ready` is 1 only while idle, and it is 0 in the cycle after an acceptance. `trap_undef` and `vec_req` never stay high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_insn | input | INSN_W | Instruction word |
| req_cp | input | CP_W | Target coprocessor number |
| req_class | input | 2 | 0 write, 1 read, 2/3 data operation |
| cp_allow | input | NUM_CP | Per-coprocessor permission bits |
| cp_strobe | output | 1 | Phase presented to the coprocessor |
| cp_phase | output | 2 | 1 first, 2 busy, 3 interrupt |
| cp_sel | output | CP_W | Selected coprocessor |
| cp_insn | output | INSN_W | Instruction presented (also for fp dispatch) |
| cp_resp | input | 2 | 0 accept, 1 busy, 2/3 cannot |
| cp_rdata | input | DATA_W | Read data, valid with an accept |
| exc_any | input | 1 | Exception-present gate |
| rst_req_n | input | 1 | Reset request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Interrupt request, active low |
| fiq_mask | input | 1 | Fast interrupt masked |
| irq_mask | input | 1 | Interrupt masked |
| cyc_type | output | 2 | 0 none, 1 internal, 2 coprocessor |
| trap_undef | output | 1 | Undefined-instruction trap pulse |
| vec_req | output | 1 | Exception vector request pulse |
| vec_code | output | 2 | 1 reset, 2 fast interrupt, 3 interrupt |
| fp_dispatch | output | 1 | Floating-point dispatch pulse |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result |
| done | output | 1 | Instruction completed |

## Verification
The hardest situation to reach is an exception that lands in one particular busy wait. It has to be gated by `exc_any` and win against masked lines of higher priority. The bench's responder answers busy a scripted number of times. It raises the chosen exception lines at the moment it gives a chosen busy answer, so the wait that follows is the first one to see them. Masked and ungated combinations check that the handshake keeps polling to completion. Randomized stall lengths move the abort point across many wait positions.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;

   typedef enum logic [1:0] {
      RSP_ACC  = 2'd0,
      RSP_BUSY = 2'd1,
      RSP_CANT = 2'd2,
      RSP_CANX = 2'd3
   } resp_e;

   typedef enum logic [1:0] {
      PH_NONE  = 2'd0,
      PH_FIRST = 2'd1,
      PH_BUSY  = 2'd2,
      PH_INTR  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      CY_NONE = 2'd0,
      CY_INT  = 2'd1,
      CY_COP  = 2'd2
   } cyc_e;

   typedef enum logic [1:0] {
      VEC_NONE = 2'd0,
      VEC_RST  = 2'd1,
      VEC_FIQ  = 2'd2,
      VEC_IRQ  = 2'd3
   } vec_e;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_FIRST = 4'd1,
      ST_WAIT  = 4'd2,
      ST_POLL  = 4'd3,
      ST_ABORT = 4'd4,
      ST_TRAP  = 4'd5,
      ST_CCYC  = 4'd6,
      ST_ICYC  = 4'd7,
      ST_FPD   = 4'd8
   } seq_state_e;

endpackage

// File: rtl/cp_exc_arbiter.sv
module cp_exc_arbiter
   import cp_seq_pkg::*;
(
   input  logic exc_any,
   input  logic rst_req_n,
   input  logic fiq_n,
   input  logic irq_n,
   input  logic fiq_mask,
   input  logic irq_mask,
   output logic take,
   output vec_e code
);

   always_comb begin
      take = 1'b0;
      code = VEC_NONE;
      if (exc_any) begin
         if (!rst_req_n) begin
            take = 1'b1;
            code = VEC_RST;
         end else if (!fiq_n && !fiq_mask) begin
            take = 1'b1;
            code = VEC_FIQ;
         end else if (!irq_n && !irq_mask) begin
            take = 1'b1;
            code = VEC_IRQ;
         end
      end
   end

endmodule

// File: rtl/cp_route_decode.sv
module cp_route_decode #(
   parameter int NUM_CP    = 16,
   parameter int CP_W      = 4,
   parameter bit FP_DIVERT = 1'b1,
   parameter int FP_CP_LO  = 10,
   parameter int FP_CP_HI  = 11
) (
   input  logic [CP_W-1:0]   cp,
   input  logic              is_op,
   input  logic [NUM_CP-1:0] allow,
   output logic              permit,
   output logic              to_fp
);

   logic [NUM_CP-1:0] fp_map;

   assign permit = allow[cp];

   if (FP_DIVERT) begin : g_fp
      for (genvar i = 0; i < NUM_CP; i++) begin : g_map
         assign fp_map[i] = (i >= FP_CP_LO) && (i <= FP_CP_HI);
      end
      assign to_fp = is_op && fp_map[cp];
   end else begin : g_nofp
      assign fp_map = '0;
      assign to_fp  = 1'b0;
   end

endmodule

// File: rtl/cp_seq_fsm.sv
module cp_seq_fsm
   import cp_seq_pkg::*;
#(
   parameter int               CP_W       = 4,
   parameter int               INSN_W     = 32,
   parameter int               DATA_W     = 32,
   parameter logic [DATA_W-1:0] TRAP_RDATA = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [INSN_W-1:0] req_insn,
   input  logic [CP_W-1:0]   req_cp,
   input  logic              req_is_rd,
   input  logic              req_is_op,
   input  logic              permit,
   input  logic              to_fp,
   input  resp_e             cp_resp,
   input  logic [DATA_W-1:0] cp_rdata,
   input  logic              exc_any,
   input  logic              exc_take,
   input  vec_e              exc_code,
   output logic              cp_strobe,
   output phase_e            cp_phase,
   output logic [CP_W-1:0]   cp_sel,
   output logic [INSN_W-1:0] cp_insn,
   output cyc_e              cyc_type,
   output logic              trap_undef,
   output logic              vec_req,
   output vec_e              vec_code,
   output logic              fp_dispatch,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   seq_state_e        state_q, state_d;
   logic [CP_W-1:0]   cp_q;
   logic [INSN_W-1:0] insn_q;
   logic              rd_q, op_q;
   logic [DATA_W-1:0] rdata_q;
   vec_e              vec_q;
   logic              done_q, done_d;
   logic              load, cap_acc, set_trap, set_abort;

   always_comb begin
      state_d   = state_q;
      done_d    = 1'b0;
      load      = 1'b0;
      cap_acc   = 1'b0;
      set_trap  = 1'b0;
      set_abort = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               load = 1'b1;
               if (to_fp) begin
                  state_d = ST_FPD;
               end else if (!permit) begin
                  state_d  = ST_TRAP;
                  set_trap = 1'b1;
               end else begin
                  state_d = ST_FIRST;
               end
            end
         end
         ST_FIRST, ST_POLL: begin
            unique case (cp_resp)
               RSP_ACC: begin
                  cap_acc = 1'b1;
                  if (op_q) begin
                     state_d = ST_IDLE;
                     done_d  = 1'b1;
                  end else begin
                     state_d = ST_CCYC;
                  end
               end
               RSP_BUSY: state_d = ST_WAIT;
               default: begin
                  state_d  = ST_TRAP;
                  set_trap = 1'b1;
               end
            endcase
         end
         ST_WAIT: begin
            if (exc_take) begin
               state_d   = ST_ABORT;
               set_abort = 1'b1;
            end else begin
               state_d = ST_POLL;
            end
         end
         ST_CCYC: begin
            if (rd_q) begin
               state_d = ST_ICYC;
            end else begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         ST_ICYC, ST_FPD: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         cp_q    <= '0;
         insn_q  <= '0;
         rd_q    <= 1'b0;
         op_q    <= 1'b0;
         rdata_q <= '0;
         vec_q   <= VEC_NONE;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (load) begin
            cp_q   <= req_cp;
            insn_q <= req_insn;
            rd_q   <= req_is_rd;
            op_q   <= req_is_op;
         end
         if (cap_acc)   rdata_q <= cp_rdata;
         if (set_trap)  rdata_q <= TRAP_RDATA;
         if (set_abort) begin
            rdata_q <= '0;
            vec_q   <= exc_code;
         end
      end
   end

   always_comb begin
      cp_strobe = 1'b0;
      cp_phase  = PH_NONE;
      cyc_type  = CY_NONE;
      unique case (state_q)
         ST_FIRST: begin cp_strobe = 1'b1; cp_phase = PH_FIRST; end
         ST_POLL:  begin cp_strobe = 1'b1; cp_phase = PH_BUSY;  end
         ST_ABORT: begin cp_strobe = 1'b1; cp_phase = PH_INTR;  end
         ST_WAIT, ST_ICYC: cyc_type = CY_INT;
         ST_CCYC:  cyc_type = CY_COP;
         default: ;
      endcase
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign cp_sel      = cp_q;
   assign cp_insn     = insn_q;
   assign trap_undef  = (state_q == ST_TRAP);
   assign vec_req     = (state_q == ST_ABORT);
   assign vec_code    = vec_q;
   assign fp_dispatch = (state_q == ST_FPD);
   assign rd_valid    = rd_q && ((state_q == ST_ICYC) || (state_q == ST_ABORT) ||
                                 (state_q == ST_TRAP));
   assign rd_data     = rdata_q;
   assign done        = done_q;

   logic polled;
   assign polled = cp_strobe && (cp_phase != PH_INTR);

   assert_denied_traps_R2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && !permit && !to_fp) |=> (trap_undef && !cp_strobe));
   assert_fp_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
      fp_dispatch |-> $past(req_valid && req_ready));
   assert_first_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
      (cp_strobe && cp_phase == PH_FIRST) |-> $past(req_valid && req_ready));
   assert_wait_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
      (polled && cp_resp == RSP_BUSY) |=> (cyc_type == CY_INT));
   assert_idle_before_poll_R5: assert property (@(posedge clk) disable iff (rst)
      (cp_strobe && cp_phase == PH_BUSY) |-> ($past(cyc_type) == CY_INT));
   assert_abort_needs_exc_R7: assert property (@(posedge clk) disable iff (rst)
      vec_req |-> $past(exc_any));
   assert_abort_notice_R6: assert property (@(posedge clk) disable iff (rst)
      vec_req |-> (cp_strobe && cp_phase == PH_INTR));
   assert_cant_traps_R8: assert property (@(posedge clk) disable iff (rst)
      (polled && cp_resp[1]) |=> trap_undef);
   assert_op_no_extra_R9: assert property (@(posedge clk) disable iff (rst)
      (polled && cp_resp == RSP_ACC && op_q) |=> (done && req_ready));
   assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      trap_undef |=> !trap_undef);
   assert_vec_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      vec_req |=> !vec_req);
   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
   import cp_seq_pkg::*;
#(
   parameter int               NUM_CP     = 16,
   parameter int               INSN_W     = 32,
   parameter int               DATA_W     = 32,
   parameter bit               FP_DIVERT  = 1'b1,
   parameter int               FP_CP_LO   = 10,
   parameter int               FP_CP_HI   = 11,
   parameter logic [DATA_W-1:0] TRAP_RDATA = {4'hF, {(DATA_W-4){1'b0}}},
   localparam int              CP_W       = $clog2(NUM_CP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [INSN_W-1:0] req_insn,
   input  logic [CP_W-1:0]   req_cp,
   input  logic [1:0]        req_class,
   input  logic [NUM_CP-1:0] cp_allow,
   output logic              cp_strobe,
   output logic [1:0]        cp_phase,
   output logic [CP_W-1:0]   cp_sel,
   output logic [INSN_W-1:0] cp_insn,
   input  logic [1:0]        cp_resp,
   input  logic [DATA_W-1:0] cp_rdata,
   input  logic              exc_any,
   input  logic              rst_req_n,
   input  logic              fiq_n,
   input  logic              irq_n,
   input  logic              fiq_mask,
   input  logic              irq_mask,
   output logic [1:0]        cyc_type,
   output logic              trap_undef,
   output logic              vec_req,
   output logic [1:0]        vec_code,
   output logic              fp_dispatch,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   if (NUM_CP < 2 || (1 << CP_W) != NUM_CP) begin : g_chk_num
      $error("NUM_CP must be a power of two of at least 2");
   end
   if (FP_DIVERT && (FP_CP_LO > FP_CP_HI || FP_CP_HI >= NUM_CP || FP_CP_LO < 0)) begin : g_chk_fp
      $error("floating-point coprocessor range is outside the coprocessor set");
   end
   if (DATA_W < 4 || INSN_W < 1) begin : g_chk_w
      $error("DATA_W must be at least 4 and INSN_W at least 1");
   end

   logic   is_rd, is_op, permit, to_fp, exc_take;
   vec_e   exc_code, vec_code_e;
   phase_e phase_e_o;
   cyc_e   cyc_e_o;

   assign is_rd = (req_class == 2'd1);
   assign is_op = req_class[1];

   cp_route_decode #(
      .NUM_CP(NUM_CP), .CP_W(CP_W), .FP_DIVERT(FP_DIVERT),
      .FP_CP_LO(FP_CP_LO), .FP_CP_HI(FP_CP_HI)
   ) route_i (
      .cp(req_cp), .is_op(is_op), .allow(cp_allow),
      .permit(permit), .to_fp(to_fp)
   );

   cp_exc_arbiter arb_i (
      .exc_any(exc_any), .rst_req_n(rst_req_n), .fiq_n(fiq_n), .irq_n(irq_n),
      .fiq_mask(fiq_mask), .irq_mask(irq_mask), .take(exc_take), .code(exc_code)
   );

   cp_seq_fsm #(
      .CP_W(CP_W), .INSN_W(INSN_W), .DATA_W(DATA_W), .TRAP_RDATA(TRAP_RDATA)
   ) fsm_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_insn(req_insn), .req_cp(req_cp), .req_is_rd(is_rd), .req_is_op(is_op),
      .permit(permit), .to_fp(to_fp), .cp_resp(resp_e'(cp_resp)), .cp_rdata(cp_rdata),
      .exc_any(exc_any), .exc_take(exc_take), .exc_code(exc_code),
      .cp_strobe(cp_strobe), .cp_phase(phase_e_o), .cp_sel(cp_sel), .cp_insn(cp_insn),
      .cyc_type(cyc_e_o), .trap_undef(trap_undef), .vec_req(vec_req),
      .vec_code(vec_code_e), .fp_dispatch(fp_dispatch), .rd_valid(rd_valid),
      .rd_data(rd_data), .done(done)
   );

   assign cp_phase = phase_e_o;
   assign cyc_type = cyc_e_o;
   assign vec_code = vec_code_e;

endmodule

// File: tb/cp_handshake_seq_tb_top.sv
module cp_handshake_seq_tb_top;

   localparam logic [31:0] TRAPV = 32'hF000_0000;
   localparam int K_STB = 0, K_CYC = 1, K_TRAP = 2, K_VEC = 3, K_FP = 4, K_RDV = 5, K_DONE = 6;

   typedef struct {
      int          cyc;
      int          kind;
      logic [63:0] val;
      string       tag;
   } exp_t;

   logic        clk = 0, rst = 1;
   logic        req_valid = 0, req_ready;
   logic [31:0] req_insn = 0;
   logic [3:0]  req_cp = 0;
   logic [1:0]  req_class = 0;
   logic [15:0] cp_allow = 16'hFFFF;
   logic        cp_strobe;
   logic [1:0]  cp_phase;
   logic [3:0]  cp_sel;
   logic [31:0] cp_insn;
   logic [1:0]  cp_resp = 0;
   logic [31:0] cp_rdata = 0;
   logic        exc_any = 0, rst_req_n = 1, fiq_n = 1, irq_n = 1, fiq_mask = 0, irq_mask = 0;
   logic [1:0]  cyc_type;
   logic        trap_undef, vec_req, fp_dispatch, rd_valid, done;
   logic [1:0]  vec_code;
   logic [31:0] rd_data;

   int   errors = 0, checks = 0, cyc = 0;
   bit   started = 0, finished = 0;
   exp_t q[$];

   int   b_busy, b_fin, b_exc_at, polls;
   bit   c_any, c_rstn, c_fiqn, c_irqn;

   cp_handshake_seq dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_insn(req_insn), .req_cp(req_cp), .req_class(req_class), .cp_allow(cp_allow),
      .cp_strobe(cp_strobe), .cp_phase(cp_phase), .cp_sel(cp_sel), .cp_insn(cp_insn),
      .cp_resp(cp_resp), .cp_rdata(cp_rdata), .exc_any(exc_any), .rst_req_n(rst_req_n),
      .fiq_n(fiq_n), .irq_n(irq_n), .fiq_mask(fiq_mask), .irq_mask(irq_mask),
      .cyc_type(cyc_type), .trap_undef(trap_undef), .vec_req(vec_req), .vec_code(vec_code),
      .fp_dispatch(fp_dispatch), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int c, input int k, input logic [63:0] v, input string tag);
      exp_t e;
      e.cyc = c; e.kind = k; e.val = v; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic observe(input int k, input logic [63:0] v);
      exp_t e;
      if (q.size() == 0) begin
         check(0, $sformatf("unexpected event kind %0d", k), v, 0);
      end else begin
         e = q.pop_front();
         check(e.kind == k && e.val == v && e.cyc == cyc,
               $sformatf("%s kind %0d/%0d cyc exp %0d", e.tag, k, e.kind, e.cyc), v, e.val);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (!rst && started) begin
         if (cp_strobe)     observe(K_STB, {26'd0, cp_phase, cp_sel, cp_insn});
         if (cyc_type != 0) observe(K_CYC, 64'(cyc_type));
         if (trap_undef)    observe(K_TRAP, 64'd0);
         if (vec_req)       observe(K_VEC, 64'(vec_code));
         if (fp_dispatch)   observe(K_FP, 64'(cp_insn));
         if (rd_valid)      observe(K_RDV, 64'(rd_data));
         if (done)          observe(K_DONE, 64'd0);
      end
   end

   // coprocessor responder
   always @(negedge clk) begin
      if (!rst && cp_strobe && cp_phase != 2'd3) begin
         if (polls < b_busy) begin
            cp_resp = 2'd1;
            if (b_exc_at >= 0 && polls == b_exc_at) begin
               exc_any = c_any; rst_req_n = c_rstn; fiq_n = c_fiqn; irq_n = c_irqn;
            end
            polls++;
         end else begin
            cp_resp = 2'(b_fin);
         end
      end
   end

   function automatic logic [63:0] stb(input int ph, input int cp, input logic [31:0] insn);
      return {26'd0, 2'(ph), 4'(cp), insn};
   endfunction

   task automatic run_insn(input int cls, input int cp, input logic [31:0] insn,
                           input logic [15:0] mask, input int busy, input int fin,
                           input int exc_at, input bit ex_any, input bit ex_rstn,
                           input bit ex_fiqn, input bit ex_irqn, input bit fm, input bit im,
                           input logic [31:0] rdv);
      int t, s, code;
      bit rd, op, tk, ab;
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      b_busy = busy; b_fin = fin; b_exc_at = exc_at; polls = 0;
      c_any = ex_any; c_rstn = ex_rstn; c_fiqn = ex_fiqn; c_irqn = ex_irqn;
      exc_any = 0; rst_req_n = 1; fiq_n = 1; irq_n = 1;
      fiq_mask = fm; irq_mask = im;
      cp_allow = mask; req_class = 2'(cls); req_cp = 4'(cp); req_insn = insn;
      cp_rdata = rdv; req_valid = 1;
      t = cyc + 1;
      rd = (cls == 1); op = (cls >= 2);
      tk = ex_any && (!ex_rstn || (!ex_fiqn && !fm) || (!ex_irqn && !im));
      code = !ex_rstn ? 1 : ((!ex_fiqn && !fm) ? 2 : 3);
      if (op && (cp == 10 || cp == 11)) begin
         push(t, K_FP, 64'(insn), "R3 fp dispatch");
         push(t + 1, K_DONE, 0, "R3 fp done");
      end else if (!mask[cp]) begin
         push(t, K_TRAP, 0, "R2 denied trap");
         if (rd) push(t, K_RDV, 64'(TRAPV), "R2 denied read value");
      end else begin
         push(t, K_STB, stb(1, cp, insn), "R4 first strobe");
         s = t; ab = 0;
         for (int i = 0; i < busy; i++) begin
            push(s + 1, K_CYC, 1, "R5 wait internal cycle");
            if (exc_at >= 0 && i >= exc_at && tk) begin
               push(s + 2, K_STB, stb(3, cp, insn), "R6 interrupt notice");
               push(s + 2, K_VEC, 64'(code), "R7 vector code");
               if (rd) push(s + 2, K_RDV, 0, "R6 abandoned read zero");
               ab = 1;
               break;
            end
            push(s + 2, K_STB, stb(2, cp, insn), "R5 busy poll");
            s = s + 2;
         end
         if (!ab) begin
            if (fin >= 2) begin
               push(s + 1, K_TRAP, 0, "R8 cannot trap");
               if (rd) push(s + 1, K_RDV, 64'(TRAPV), "R8 cannot read value");
            end else if (op) begin
               push(s + 1, K_DONE, 0, "R9 op done no extra");
            end else if (rd) begin
               push(s + 1, K_CYC, 2, "R9 read coproc cycle");
               push(s + 2, K_CYC, 1, "R9 read internal cycle");
               push(s + 2, K_RDV, 64'(rdv), "R9 read data");
               push(s + 3, K_DONE, 0, "R9 read done");
            end else begin
               push(s + 1, K_CYC, 2, "R9 write coproc cycle");
               push(s + 2, K_DONE, 0, "R9 write done");
            end
         end
      end
      @(negedge clk);
      req_valid = 0;
      check(req_ready == 0, "R10 ready low after accept", 64'(req_ready), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      check(req_ready == 1, "R1 ready after reset", 64'(req_ready), 1);
      check({cp_strobe, trap_undef, vec_req, fp_dispatch, rd_valid, done} == 0,
            "R1 pulses low after reset",
            64'({cp_strobe, trap_undef, vec_req, fp_dispatch, rd_valid, done}), 0);
      check(cyc_type == 0, "R1 no cycle type after reset", 64'(cyc_type), 0);
      started = 1;
      //       cls cp insn          mask     busy fin exc any rstn fiqn irqn fm im rdata
      run_insn(0, 3, 32'h1111_0003, 16'hFFFF, 0, 0, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(1, 5, 32'h2222_0005, 16'hFFFF, 2, 0, -1, 0, 1, 1, 1, 0, 0, 32'hCAFE_0001);
      run_insn(2, 7, 32'h3333_0007, 16'hFFFF, 1, 0, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(0, 4, 32'h4444_0004, 16'hFFEF, 0, 0, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(1, 9, 32'h5555_0009, 16'hFDFF, 0, 0, -1, 0, 1, 1, 1, 0, 0, 32'h5);
      run_insn(2, 10, 32'h6666_000A, 16'h0000, 0, 0, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(3, 11, 32'h7777_000B, 16'hFFFF, 0, 0, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(1, 10, 32'h8888_000A, 16'hFFFF, 1, 0, -1, 0, 1, 1, 1, 0, 0, 32'hBEEF_0A0A);
      run_insn(1, 2, 32'h9999_0002, 16'hFFFF, 0, 2, -1, 0, 1, 1, 1, 0, 0, 32'h1);
      run_insn(0, 6, 32'hAAAA_0006, 16'hFFFF, 3, 3, -1, 0, 1, 1, 1, 0, 0, 32'h0);
      run_insn(1, 1, 32'hBBBB_0001, 16'hFFFF, 4, 0, 1, 1, 1, 1, 0, 0, 0, 32'h77);
      run_insn(0, 8, 32'hCCCC_0008, 16'hFFFF, 3, 0, 0, 1, 1, 0, 0, 0, 0, 32'h0);
      run_insn(2, 0, 32'hDDDD_0000, 16'hFFFF, 3, 0, 2, 1, 0, 0, 0, 0, 0, 32'h0);
      run_insn(1, 12, 32'hEEEE_000C, 16'hFFFF, 3, 0, 0, 0, 0, 0, 0, 0, 0, 32'h1234);
      run_insn(0, 13, 32'hF0F0_000D, 16'hFFFF, 3, 0, 0, 1, 1, 0, 0, 1, 1, 32'h0);
      run_insn(0, 14, 32'h0F0F_000E, 16'hFFFF, 2, 0, 0, 1, 1, 0, 0, 0, 1, 32'h0);
      for (int n = 0; n < 60; n++) begin
         int cls, cp, fin;
         logic [15:0] mask;
         cls  = int'($urandom_range(0, 3));
         cp   = int'($urandom_range(0, 15));
         mask = ($urandom_range(0, 3) == 0) ? ~(16'(1) << cp) : 16'hFFFF;
         fin  = ($urandom_range(0, 4) == 0) ? 2 : 0;
         run_insn(cls, cp, $urandom, mask, int'($urandom_range(0, 6)), fin,
                  ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 5)),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), $urandom);
      end
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R9 all expected events seen", 64'(q.size()), 0);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired, pending=%0d", q.size());
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule